// File: doc/BRIEF.md
# Serial Port Byte Queues with Threshold Interrupts

This block sits between a processor register port and the transmit and receive halves of a serial engine. It holds two byte queues of equal depth. Software writes bytes into the transmit queue through a data register, and the serial transmitter takes them from the queue head through a pop strobe. The serial receiver pushes received bytes into the receive queue, and software drains them by reading a data register, where each read removes the byte it returns.

Each queue has its own control word. It holds an enable, a flush command that clears itself, and a six-bit trigger level. A single status word reports both fill counts and the free space in the transmit queue. Three sticky flags are kept: transmit, receive and error. The transmit flag sets when the transmit queue drains to its trigger level. The receive flag sets when the receive queue fills to its trigger level. The error flag sets on a receive overrun. Each flag is gated onto its own request line by an enable mask, and software clears the flags by writing ones.

Top module: `uart_fifo_ctl`

## Requirements
- R1: The register port uses word addresses 0 (transmit control) and 1 (receive control). Each control word has enable in bit 0, flush in bit 1 and the trigger level in bits 13:8. A read returns enable and level, with bit 1 always 0. After reset every register and flag reads 0.
- R2: A control write with bit 1 set, or with bit 0 clear, empties that queue by the next cycle. A pop or read in the same cycle has no effect.
- R3: While a queue is disabled, pushes to it are ignored. Its fill count reads 0, and the transmit free count reads 0.
- R4: The status word at address 2 holds the receive fill count in bits 5:0, the transmit fill count in bits 13:8 and the transmit free count (depth minus fill, when enabled) in bits 29:24. All other bits are 0.
- R5: A write to address 5 appends bits 7:0 to the transmit queue when it is enabled and not full. A write to a full queue is ignored. `tx_avail` is high while the queue holds a byte, `tx_data` shows the oldest byte, and `tx_pop` removes it, in first-in first-out order.
- R6: `rx_push` appends `rx_byte` to the enabled receive queue. While the queue holds data, address 6 returns the oldest byte in bits 7:0; otherwise it returns 0. A read with `reg_re` removes that byte.
- R7: A push to a full enabled receive queue drops the byte, pulses `rx_overrun` high in that same cycle, and sets the error flag.
- R8: The receive flag sets when an accepted push (without a same-cycle pop) brings the receive fill count to at least its trigger level.
- R9: The transmit flag sets when an accepted pop (without a same-cycle push) brings the transmit fill count to at most its trigger level.
- R10: The enable mask at address 3 gates flags onto the request lines: bit 0 to `irq_tx`, bit 1 to `irq_rx` and bit 2 to `irq_err`. Bit 3 raises `irq_txbuf` while the transmit queue is enabled and empty.
- R11: Writing to address 4 clears the transmit, receive and error flags for ones in bits 0, 1 and 2. A flag that sets in the same cycle stays set. Reading address 4 returns the flags in those bit positions.
- R12: `tx_idle` is high exactly when the transmit fill count is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops receive data at address 6) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |
| tx_pop | input | 1 | Serial transmitter takes the head byte |
| tx_data | output | 8 | Transmit queue head byte |
| tx_avail | output | 1 | Transmit queue holds at least one byte |
| tx_idle | output | 1 | Transmit fill count is zero |
| rx_push | input | 1 | Serial receiver offers a byte |
| rx_byte | input | 8 | Received byte |
| rx_overrun | output | 1 | Receive byte dropped on a full queue |
| irq_tx | output | 1 | Transmit threshold request |
| irq_rx | output | 1 | Receive threshold request |
| irq_err | output | 1 | Error request |
| irq_txbuf | output | 1 | Transmit queue empty request |

## Verification
The assertions assume that the register port never raises `reg_we` and `reg_re` in the same cycle, so a flush never coincides with a data write or data read on one queue. They also assume that the engine side and the register side can act in the same cycle. The stimulus drives only one register strobe at a time, at the falling edge. In both the scripted phases and the random phase it freely overlaps engine pushes and pops with register traffic, which covers same-cycle set and clear, pushes to full queues and pops from empty ones.

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    reg_addr,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_data,
  output logic          tx_avail,
  output logic          tx_idle,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_byte,
  output logic          rx_overrun,
  output logic          irq_tx,
  output logic          irq_rx,
  output logic          irq_err,
  output logic          irq_txbuf
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int LW = 6;
  localparam logic [2:0] A_TXC = 3'd0, A_RXC = 3'd1, A_STAT = 3'd2, A_IEN = 3'd3,
                         A_FLAG = 3'd4, A_TXD = 3'd5, A_RXD = 3'd6;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt, tx_free;
  logic          tx_en, rx_en;
  logic [LW-1:0] tx_lvl, rx_lvl;
  logic [3:0]    ien;
  logic [2:0]    flag, flag_set, flag_clr;

  wire tx_clr     = reg_we && reg_addr == A_TXC && (reg_wdata[1] || !reg_wdata[0]);
  wire rx_clr     = reg_we && reg_addr == A_RXC && (reg_wdata[1] || !reg_wdata[0]);
  wire tx_push_ok = reg_we && reg_addr == A_TXD && tx_en && tx_cnt != FULL;
  wire tx_pop_ok  = tx_pop && tx_cnt != '0 && !tx_clr;
  wire rx_push_ok = rx_push && rx_en && rx_cnt != FULL && !rx_clr;
  wire rx_pop_ok  = reg_re && reg_addr == A_RXD && rx_cnt != '0 && !rx_clr;

  assign rx_overrun = rx_push && rx_en && rx_cnt == FULL;
  assign tx_free    = tx_en ? FULL - tx_cnt : '0;
  assign tx_data    = tx_mem[tx_rp];
  assign tx_avail   = tx_cnt != '0;
  assign tx_idle    = tx_cnt == '0;

  assign flag_set[0] = tx_pop_ok && !tx_push_ok && LW'(tx_cnt - CW'(1)) <= tx_lvl;
  assign flag_set[1] = rx_push_ok && !rx_pop_ok && LW'(rx_cnt + CW'(1)) >= rx_lvl;
  assign flag_set[2] = rx_overrun;
  assign flag_clr    = (reg_we && reg_addr == A_FLAG) ? reg_wdata[2:0] : 3'b0;

  assign irq_tx    = flag[0] && ien[0];
  assign irq_rx    = flag[1] && ien[1];
  assign irq_err   = flag[2] && ien[2];
  assign irq_txbuf = ien[3] && tx_en && tx_cnt == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en <= 1'b0; rx_en <= 1'b0;
      tx_lvl <= '0;  rx_lvl <= '0;
      ien <= '0;     flag <= '0;
    end else begin
      if (reg_we && reg_addr == A_TXC) begin
        tx_en  <= reg_wdata[0];
        tx_lvl <= reg_wdata[8 +: LW];
      end
      if (reg_we && reg_addr == A_RXC) begin
        rx_en  <= reg_wdata[0];
        rx_lvl <= reg_wdata[8 +: LW];
      end
      if (reg_we && reg_addr == A_IEN) ien <= reg_wdata[3:0];
      flag <= (flag & ~flag_clr) | flag_set;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || tx_clr) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push_ok) tx_wp <= tx_wp + PW'(1);
      if (tx_pop_ok)  tx_rp <= tx_rp + PW'(1);
      case ({tx_push_ok, tx_pop_ok})
        2'b10:   tx_cnt <= tx_cnt + CW'(1);
        2'b01:   tx_cnt <= tx_cnt - CW'(1);
        default: tx_cnt <= tx_cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rx_clr) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push_ok) rx_wp <= rx_wp + PW'(1);
      if (rx_pop_ok)  rx_rp <= rx_rp + PW'(1);
      case ({rx_push_ok, rx_pop_ok})
        2'b10:   rx_cnt <= rx_cnt + CW'(1);
        2'b01:   rx_cnt <= rx_cnt - CW'(1);
        default: rx_cnt <= rx_cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push_ok) tx_mem[tx_wp] <= reg_wdata[DW-1:0];
    if (rx_push_ok) rx_mem[rx_wp] <= rx_byte;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_TXC:  reg_rdata = {18'b0, tx_lvl, 7'b0, tx_en};
      A_RXC:  reg_rdata = {18'b0, rx_lvl, 7'b0, rx_en};
      A_STAT: reg_rdata = {2'b0, LW'(tx_free), 10'b0, LW'(tx_cnt), 2'b0, LW'(rx_cnt)};
      A_IEN:  reg_rdata = {28'b0, ien};
      A_FLAG: reg_rdata = {29'b0, flag};
      A_RXD:  reg_rdata = (rx_cnt != '0) ? 32'(rx_mem[rx_rp]) : 32'b0;
      default: reg_rdata = '0;
    endcase
  end

  p_flush_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_TXC && reg_wdata[1]) |=> tx_cnt == '0);
  p_disabled_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> rx_cnt == '0);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL && rx_cnt <= FULL);
  p_overrun_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !reg_re && !reg_we) |=> (rx_cnt == FULL && flag[2]));
  p_txfree_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> (tx_free + tx_cnt == FULL));
  p_idle_pop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_idle && tx_pop && !reg_we) |=> tx_idle);
endmodule

// File: tb/test_uart_fifo_ctl.sv
module test_uart_fifo_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic tx_pop = 1'b0;
  logic [7:0] tx_data;
  logic tx_avail, tx_idle;
  logic rx_push = 1'b0;
  logic [7:0] rx_byte = '0;
  logic rx_overrun, irq_tx, irq_rx, irq_err, irq_txbuf;

  always #5 clk = ~clk;

  uart_fifo_ctl i_uart_fifo_ctl (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  byte unsigned txq[$], rxq[$];
  bit m_txen, m_rxen;
  int m_txlvl, m_rxlvl;
  bit [3:0] m_ien;
  bit [2:0] m_flag;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rdata(logic [2:0] a);
    int txf;
    txf = m_txen ? 16 - txq.size() : 0;
    case (a)
      3'd0: return (32'(m_txlvl) << 8) | 32'(m_txen);
      3'd1: return (32'(m_rxlvl) << 8) | 32'(m_rxen);
      3'd2: return 32'(rxq.size()) | (32'(txq.size()) << 8) | (32'(txf) << 24);
      3'd3: return 32'(m_ien);
      3'd4: return 32'(m_flag);
      3'd6: return rxq.size() != 0 ? 32'(rxq[0]) : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic compare();
    string rq;
    case (reg_addr)
      3'd0, 3'd1: rq = "R1";
      3'd2: rq = "R4";
      3'd3: rq = "R10";
      3'd4: rq = "R11";
      3'd6: rq = "R6";
      default: rq = "R4";
    endcase
    chk(rq, reg_rdata, exp_rdata(reg_addr));
    chk("R5 tx_avail", 32'(tx_avail), 32'(txq.size() != 0));
    if (txq.size() != 0) chk("R5 tx_data", 32'(tx_data), 32'(txq[0]));
    chk("R12 tx_idle", 32'(tx_idle), 32'(txq.size() == 0));
    chk("R7 rx_overrun", 32'(rx_overrun), 32'(rx_push && m_rxen && rxq.size() == 16));
    chk("R10 irq_tx", 32'(irq_tx), 32'(m_flag[0] & m_ien[0]));
    chk("R10 irq_rx R8", 32'(irq_rx), 32'(m_flag[1] & m_ien[1]));
    chk("R10 irq_err", 32'(irq_err), 32'(m_flag[2] & m_ien[2]));
    chk("R10 irq_txbuf", 32'(irq_txbuf), 32'(m_ien[3] && m_txen && txq.size() == 0));
  endtask

  task automatic model_update();
    bit txclr, rxclr, tpush, tpop, rpush, rpop, ovr;
    bit [2:0] set, clr;
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      m_txen = 0; m_rxen = 0; m_txlvl = 0; m_rxlvl = 0; m_ien = 0; m_flag = 0;
      return;
    end
    txclr = reg_we && reg_addr == 0 && (reg_wdata[1] || !reg_wdata[0]);
    rxclr = reg_we && reg_addr == 1 && (reg_wdata[1] || !reg_wdata[0]);
    tpush = reg_we && reg_addr == 5 && m_txen && txq.size() < 16;
    tpop  = tx_pop && txq.size() > 0 && !txclr;
    rpush = rx_push && m_rxen && rxq.size() < 16 && !rxclr;
    rpop  = reg_re && reg_addr == 6 && rxq.size() > 0 && !rxclr;
    ovr   = rx_push && m_rxen && rxq.size() == 16;
    set[0] = tpop && !tpush && (txq.size() - 1) <= m_txlvl;
    set[1] = rpush && !rpop && (rxq.size() + 1) >= m_rxlvl;
    set[2] = ovr;
    clr = (reg_we && reg_addr == 4) ? reg_wdata[2:0] : 3'b0;
    m_flag = (m_flag & ~clr) | set;
    if (txclr) txq.delete();
    else begin
      if (tpop) void'(txq.pop_front());
      if (tpush) txq.push_back(reg_wdata[7:0]);
    end
    if (rxclr) rxq.delete();
    else begin
      if (rpop) void'(rxq.pop_front());
      if (rpush) rxq.push_back(rx_byte);
    end
    if (reg_we && reg_addr == 0) begin m_txen = reg_wdata[0]; m_txlvl = int'(reg_wdata[13:8]); end
    if (reg_we && reg_addr == 1) begin m_rxen = reg_wdata[0]; m_rxlvl = int'(reg_wdata[13:8]); end
    if (reg_we && reg_addr == 3) m_ien = reg_wdata[3:0];
  endtask

  task automatic cyc();
    #1 compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
    reg_we = 0; reg_re = 0; tx_pop = 0; rx_push = 0; reg_addr = 3'd2;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1; cyc();
  endtask

  task automatic rd(logic [2:0] a);
    reg_addr = a; reg_re = 1; cyc();
  endtask

  task automatic eng(bit push, byte unsigned b, bit pop);
    rx_push = push; rx_byte = b; tx_pop = pop; cyc();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    model_update();
    for (int i = 0; i < 3; i++) begin
      for (int a = 0; a < 7; a++) begin reg_addr = 3'(a); #1 compare(); end
      @(negedge clk);
    end
    rst_n = 1;
    // R1 R10 R11 reset values, then configuration readback (flush bit reads 0)
    for (int a = 0; a < 7; a++) rd(3'(a));
    wr(3'd0, 32'h0000_0203); rd(3'd0);
    wr(3'd1, 32'h0000_0301); rd(3'd1);
    wr(3'd3, 32'h0000_000F); rd(3'd3);
    // R5 R9 transmit fill and drain through the trigger level
    for (int i = 0; i < 5; i++) wr(3'd5, 32'hA0 + 32'(i));
    rd(3'd2);
    for (int i = 0; i < 5; i++) begin eng(0, 0, 1); rd(3'd4); end
    eng(0, 0, 1);
    wr(3'd4, 32'h1); rd(3'd4);
    // R5 transmit full: extra writes ignored, then R2 flush
    for (int i = 0; i < 18; i++) wr(3'd5, 32'h10 + 32'(i));
    rd(3'd2);
    wr(3'd0, 32'h0000_0203); rd(3'd2); rd(3'd0);
    // R6 R7 R8 receive fill, overrun, drain
    for (int i = 0; i < 18; i++) eng(1, byte'(8'h40 + i), 0);
    rd(3'd4); rd(3'd2);
    for (int i = 0; i < 4; i++) rd(3'd6);
    wr(3'd4, 32'h7); rd(3'd4);
    // R11 same-cycle set and clear: push reaching level while clearing
    wr(3'd1, 32'h0000_0003); wr(3'd1, 32'h0000_0101);
    rx_push = 1; rx_byte = 8'h77; reg_addr = 3'd4; reg_wdata = 32'h2; reg_we = 1; cyc();
    rd(3'd4);
    // R3 disabled queues ignore pushes and read as empty
    wr(3'd1, 32'h0000_0100); eng(1, 8'h55, 0); rd(3'd2); rd(3'd6);
    wr(3'd0, 32'h0); wr(3'd5, 32'h99); rd(3'd2);
    wr(3'd0, 32'h0000_0401); wr(3'd1, 32'h0000_0801);
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom_range(0, 15));
      rx_push = $urandom_range(0, 2) == 0;
      rx_byte = byte'($urandom);
      tx_pop  = $urandom_range(0, 2) == 0;
      reg_addr = 3'($urandom_range(0, 6));
      reg_wdata = $urandom;
      if (op < 5) begin reg_addr = 3'd5; reg_we = 1; end
      else if (op < 9) begin reg_addr = 3'd6; reg_re = 1; end
      else if (op == 9) begin
        reg_addr = 3'($urandom_range(0, 1));
        reg_wdata = {18'b0, 6'($urandom_range(0, 17)), 6'b0, 1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 5) != 0)};
        reg_we = 1;
      end
      else if (op == 10) begin reg_addr = 3'd4; reg_we = 1; end
      else if (op == 11) begin reg_addr = 3'd3; reg_we = 1; end
      cyc();
      if (!m_txen && $urandom_range(0, 3) == 0) wr(3'd0, 32'h0000_0301);
      if (!m_rxen && $urandom_range(0, 3) == 0) wr(3'd1, 32'h0000_0501);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule